// File: doc/BRIEF.md
# Ring-Buffer Occupancy Mask Tracker

This block keeps track of which entries of an eight-entry circular buffer are in use. Examples are the block entries of a load/store queue or the slots of a retirement window. It holds a head pointer to the oldest live entry, a tail pointer to the youngest live entry and an empty flag. An allocate strobe extends the tail and a retire strobe releases the head. Both pointers wrap from the last slot back to slot 0.

Every cycle the block presents a mask with one bit per slot, set for each occupied slot. The mask comes from the stored pointers through combinational logic only. It needs no walk over the slots: a "slot index at or below the tail" mask is combined with a "slot index at or above the head" mask. The two are ANDed when the live range is contiguous and ORed when it crosses the wrap point. The block also reports whether the buffer is full, so that the producer can hold off its allocations.

Top module: `ring_valid_tracker`

## Requirements
- R1: A synchronous reset sets both pointers to 0, raises empty, lowers full and drives an all-zero mask.
- R2: Whenever empty is high, the mask is all zeros, whatever the pointer values are.
- R3: When not empty and tail is numerically greater than head, exactly the mask bits with index from head to tail (both included) are set.
- R4: When not empty and tail is numerically less than head, exactly the bits from head up to 7 and from 0 up to tail are set.
- R5: When not empty and head equals tail, exactly one mask bit is set: bit number head.
- R6: An allocate into an empty buffer clears empty and leaves the tail equal to the head. A retire in the same cycle is ignored.
- R7: An allocate into a buffer that is neither empty nor full advances the tail by one, from 7 to 0 on wrap.
- R8: A retire alone with head equal to tail sets empty and leaves both pointers unchanged. A retire alone in any other non-empty state advances the head by one, from 7 to 0 on wrap.
- R9: Full is high exactly when the buffer is not empty and tail+1 (mod 8) equals head. An allocate while full is ignored. If a retire comes in the same cycle, only the retire acts.
- R10: A retire while empty is ignored: pointers and empty are unchanged.
- R11: An allocate and a retire in the same cycle on a buffer that is neither empty nor full advance both pointers by one and keep the occupied count unchanged.
- R12: With neither strobe high, pointers and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_i | input | 1 | Request to occupy the slot after the tail |
| retire_i | input | 1 | Request to release the slot at the head |
| head_o | output | 3 | Index of the oldest occupied slot |
| tail_o | output | 3 | Index of the youngest occupied slot |
| empty_o | output | 1 | No slot is occupied |
| full_o | output | 1 | All eight slots are occupied |
| mask_o | output | 8 | One bit per slot, set when that slot is occupied |

## Verification
A wrong pointer or empty flag shows up in the same cycle as a mask with the wrong population count or a gap in the wrong place, because the mask is a pure function of the stored state. A wrong step on a strobe appears on the pointer ports right after the next rising edge. The bench sweeps long runs of strobes biased toward filling, draining and simultaneous traffic, so every head/tail pair, both wrap directions and both boundary flags are reached. It compares every output every cycle against an occupancy-count model.

// File: rtl/ring_valid_pkg.sv
package ring_valid_pkg;

  // Modular step of a slot index; slot count need not be a power of two.
  function automatic int unsigned slot_step(input int unsigned idx, input int unsigned slots);
    return (idx + 1 >= slots) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             retire,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             empty,
  output logic             full,
  output logic             take_alloc,
  output logic             take_retire
);
  import ring_valid_pkg::*;

  logic [PTR_W-1:0] head_q, tail_q, head_inc, tail_inc;
  logic             empty_q;

  assign head_inc = PTR_W'(slot_step(int'(head_q), SLOTS));
  assign tail_inc = PTR_W'(slot_step(int'(tail_q), SLOTS));

  assign full        = !empty_q && (tail_inc == head_q);
  assign take_alloc  = alloc && !full;
  assign take_retire = retire && !empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      empty_q <= 1'b1;
    end else if (take_alloc && empty_q) begin
      empty_q <= 1'b0;
    end else begin
      if (take_alloc) tail_q <= tail_inc;
      if (take_retire) begin
        if (!take_alloc && head_q == tail_q) empty_q <= 1'b1;
        else                                 head_q  <= head_inc;
      end
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign empty = empty_q;
endmodule

// File: rtl/ring_mask_gen.sv
module ring_mask_gen #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  logic             empty,
  output logic [SLOTS-1:0] mask,
  output logic             wrapped
);
  logic [SLOTS-1:0] upto_tail, from_head;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign upto_tail[i] = (i <= int'(tail));
    assign from_head[i] = (i >= int'(head));
  end

  assign wrapped = tail < head;

  always_comb begin
    if (empty)        mask = '0;
    else if (wrapped) mask = upto_tail | from_head;
    else              mask = upto_tail & from_head;
  end
endmodule

// File: rtl/ring_valid_tracker.sv
module ring_valid_tracker #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_i,
  input  logic             retire_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [SLOTS-1:0] mask_o
);
  logic take_alloc, take_retire, range_wrapped;

  ring_ptr_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .alloc      (alloc_i),
    .retire     (retire_i),
    .head       (head_o),
    .tail       (tail_o),
    .empty      (empty_o),
    .full       (full_o),
    .take_alloc (take_alloc),
    .take_retire(take_retire)
  );

  ring_mask_gen #(.SLOTS(SLOTS)) u_mask (
    .head   (head_o),
    .tail   (tail_o),
    .empty  (empty_o),
    .mask   (mask_o),
    .wrapped(range_wrapped)
  );
endmodule

// File: rtl/ring_valid_tracker_chk.sv
module ring_valid_tracker_chk #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_i,
  input logic             retire_i,
  input logic [PTR_W-1:0] head_o,
  input logic [PTR_W-1:0] tail_o,
  input logic             empty_o,
  input logic             full_o,
  input logic [SLOTS-1:0] mask_o,
  input logic             take_alloc,
  input logic             take_retire,
  input logic             range_wrapped
);
  import ring_valid_pkg::*;

  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> mask_o == '0);

  assert_single_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (!empty_o && head_o == tail_o) |-> ($countones(mask_o) == 1 && mask_o[head_o]));

  assert_ends_set_R3: assert property (@(posedge clk) disable iff (rst)
    !empty_o |-> (mask_o[head_o] && mask_o[tail_o]));

  assert_wrap_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!empty_o && range_wrapped) |-> mask_o[0]);

  assert_full_mask_R9: assert property (@(posedge clk) disable iff (rst)
    full_o |-> (&mask_o));

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (full_o && alloc_i && !retire_i) |=> ($stable(tail_o) && $stable(head_o) && full_o));

  assert_empty_retire_R10: assert property (@(posedge clk) disable iff (rst)
    (empty_o && retire_i && !alloc_i) |=> ($stable(head_o) && $stable(tail_o) && empty_o));

  assert_count_kept_R11: assert property (@(posedge clk) disable iff (rst)
    (take_alloc && take_retire && !empty_o) |=>
      ($countones(mask_o) == $past($countones(mask_o))));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!alloc_i && !retire_i) |=> ($stable(head_o) && $stable(tail_o) && $stable(empty_o)));

  assert_first_alloc_R6: assert property (@(posedge clk) disable iff (rst)
    (empty_o && take_alloc) |=> (!empty_o && head_o == tail_o));

  assert_tail_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!empty_o && take_alloc) |=> (int'(tail_o) == slot_step(int'($past(tail_o)), SLOTS)));
endmodule

bind ring_valid_tracker ring_valid_tracker_chk #(.SLOTS(SLOTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_i      (alloc_i),
  .retire_i     (retire_i),
  .head_o       (head_o),
  .tail_o       (tail_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .mask_o       (mask_o),
  .take_alloc   (take_alloc),
  .take_retire  (take_retire),
  .range_wrapped(range_wrapped)
);

// File: tb/ring_valid_tracker_test.sv
module ring_valid_tracker_test;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_i = 1'b0;
  logic       retire_i = 1'b0;
  logic [2:0] head_o, tail_o;
  logic       empty_o, full_o;
  logic [7:0] mask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference: head index and occupied count.
  int    ref_head = 0;
  int    ref_cnt  = 0;
  string last_tag = "R1";

  always #4 clk = ~clk;

  ring_valid_tracker uut (
    .clk(clk), .rst(rst), .alloc_i(alloc_i), .retire_i(retire_i),
    .head_o(head_o), .tail_o(tail_o), .empty_o(empty_o),
    .full_o(full_o), .mask_o(mask_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_tail();
    return (ref_cnt == 0) ? ref_head : (ref_head + ref_cnt - 1) % N;
  endfunction

  function automatic logic [7:0] ref_mask();
    logic [7:0] m = '0;
    for (int k = 0; k < ref_cnt; k++) m[(ref_head + k) % N] = 1'b1;
    return m;
  endfunction

  task automatic compare_all();
    string mtag;
    int    t = ref_tail();
    if (ref_cnt == 0)          mtag = "R2";
    else if (t == ref_head)    mtag = "R5";
    else if (t < ref_head)     mtag = "R4";
    else                       mtag = "R3";
    check(mtag, "mask", int'(mask_o), int'(ref_mask()));
    check(last_tag, "empty", int'(empty_o), int'(ref_cnt == 0));
    check("R9", "full", int'(full_o), int'(ref_cnt == N));
    check(last_tag, "head", int'(head_o), ref_head);
    check(last_tag, "tail", int'(tail_o), t);
  endtask

  // Apply one step to the reference and record which rule governs it.
  task automatic ref_step(input bit a, input bit r);
    if (ref_cnt == 0) begin
      if (a) begin ref_cnt = 1; last_tag = "R6"; end
      else if (r) last_tag = "R10";
      else        last_tag = "R12";
    end else if (ref_cnt == N && a) begin
      last_tag = "R9";
      if (r) begin ref_head = (ref_head + 1) % N; ref_cnt--; end
    end else if (a && r) begin
      ref_head = (ref_head + 1) % N; last_tag = "R11";
    end else if (a) begin
      ref_cnt++; last_tag = "R7";
    end else if (r) begin
      if (ref_cnt > 1) ref_head = (ref_head + 1) % N;
      ref_cnt--; last_tag = "R8";
    end else last_tag = "R12";
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "reset head", int'(head_o), 0);
    check("R1", "reset tail", int'(tail_o), 0);
    check("R1", "reset empty", int'(empty_o), 1);
    check("R1", "reset full", int'(full_o), 0);
    check("R1", "reset mask", int'(mask_o), 0);
    for (int c = 0; c < 4000; c++) begin
      int  phase = (c / 48) % 5;
      int  pa, pr;
      bit  a, r;
      case (phase)
        0: begin pa = 90; pr = 10; end
        1: begin pa = 50; pr = 50; end
        2: begin pa = 10; pr = 90; end
        3: begin pa = 85; pr = 80; end
        default: begin pa = 30; pr = 30; end
      endcase
      a = ($urandom_range(0, 99) < pa);
      r = ($urandom_range(0, 99) < pr);
      alloc_i  = a;
      retire_i = r;
      ref_step(a, r);
      @(negedge clk);
      compare_all();
    end
    alloc_i = 1'b0; retire_i = 1'b0;
    finish_run();
  end

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule